// File: doc/BRIEF.md
# Masked Radio Interrupt Controller

This block gathers the three completion events of a radio link-layer engine (a transmit that finished, a received payload waiting, and a transmit that gave up after its retry limit) into one active-low interrupt request line. Each event leaves a sticky flag in a status register. Software reads the flags through a small register port and clears them by writing ones. A mask register chooses which flags may pull the line low. A flag whose source is masked still sets, so software can poll it.

The status register also carries a 3-bit receive pipe number. This number is loaded from the engine only on the clock edge at which the request line drops. A read taken in the cycle that ends with that edge returns the pipe number from before the drop, and the block marks such a read with an unreliable-read strobe.

The line is driven by a two-state machine. In `IDLE` the line is high. In `FIRE` the line is low. The transition `IDLE -> FIRE` (named *assert*) happens when any unmasked flag is pending, and the pipe number is captured on that transition. The transition `FIRE -> IDLE` (named *release*) happens when nothing unmasked is pending. In both states the machine stays put (*hold*) otherwise.

Top module: `radio_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, the status register reads 0x00 and the mask register reads 0x00.
- R2: An event pulse sets its flag on the clock edge that samples it. Status bit 0 is transmit-done, bit 1 is receive-ready and bit 2 is max-retry. Flags stay set until cleared.
- R3: A write to address 0 clears each flag whose write-data bit (bits 2:0) is 1. Flags whose write-data bit is 0 are unchanged.
- R4: If a flag's event and a write-one-to-clear of that flag arrive in the same cycle, the flag is set after the edge.
- R5: `irq_n` goes to 0 on the clock edge after the edge that made an unmasked flag pending, which is one cycle of latency.
- R6: A flag whose mask bit is 1 still sets, but it never drives `irq_n` low.
- R7: `irq_n` returns to 1 on the edge after the one at which the last pending unmasked flag was cleared or masked.
- R8: Status bits 6:4 load `rx_pipe` on the edge at which `irq_n` changes from 1 to 0, and hold their value on every other edge. Bits 7 and 3 read 0.
- R9: `rd_unreliable` is 1 exactly when `reg_rd` is high in a cycle whose closing edge drives `irq_n` from 1 to 0. The data of that read shows the previous pipe number.
- R10: Address 1 is the mask register, with bits 2:0 matching the status flag bits. Writes to it load bits 2:0, and it reads back with bits 7:3 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_done | input | 1 | Transmit-done event pulse |
| ev_rx_ready | input | 1 | Receive-data-ready event pulse |
| ev_max_retry | input | 1 | Retry-limit-reached event pulse |
| rx_pipe | input | 3 | Receive pipe number from the link engine |
| reg_addr | input | 1 | Register select: 0 status, 1 mask |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (qualifies `rd_unreliable`) |
| reg_rdata | output | 8 | Read data for the selected register |
| rd_unreliable | output | 1 | Read taken in the cycle the pipe number is captured |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A flag that is lost or stuck shows up in the status read data in the cycle right after the edge concerned. One edge later it also shows on `irq_n`, unless that source is masked. If the state machine is wrong, `irq_n` or the strobe moves one edge early or late. If the pipe number is captured on the wrong edge, status bits 6:4 differ from the expected value as soon as `rx_pipe` changes while the line is held low. Because every output is compared on every cycle, any of these faults is reported within one or two cycles of its cause.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
    localparam int unsigned NUM_SRC    = 3;
    localparam int unsigned PIPE_W     = 3;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned PIPE_LSB   = 4;

    localparam int unsigned SRC_TX     = 0;
    localparam int unsigned SRC_RX     = 1;
    localparam int unsigned SRC_RETRY  = 2;

    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_MASK   = 1'b1;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_FIRE = 1'b1
    } irq_state_t;
endpackage

// File: rtl/radio_irq_flags.sv
module radio_irq_flags
    import radio_irq_pkg::*;
#(
    parameter int unsigned N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= 1'b0;
            end else if (ev[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/radio_irq_fsm.sv
module radio_irq_fsm
    import radio_irq_pkg::*;
#(
    parameter int unsigned PW = PIPE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pending,
    input  logic [PW-1:0] pipe_in,
    output logic          irq_n,
    output logic          fall,
    output logic [PW-1:0] pipe_q
);
    irq_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (pending)  state_d = IRQ_FIRE;
            IRQ_FIRE: if (!pending) state_d = IRQ_IDLE;
            default:                state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else if (fall) begin
            pipe_q <= pipe_in;
        end
    end

    always_comb begin
        irq_n = 1'b1;
        fall  = 1'b0;
        unique case (state_q)
            IRQ_IDLE: begin
                irq_n = 1'b1;
                fall  = pending;
            end
            IRQ_FIRE: begin
                irq_n = 1'b0;
                fall  = 1'b0;
            end
            default: begin
                irq_n = 1'b1;
                fall  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
    import radio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_done,
    input  logic              ev_rx_ready,
    input  logic              ev_max_retry,
    input  logic [PIPE_W-1:0] rx_pipe,
    input  logic              reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              rd_unreliable,
    output logic              irq_n
);
    localparam int unsigned PAD_HI = DATA_W - PIPE_LSB - PIPE_W;
    localparam int unsigned PAD_MID = PIPE_LSB - NUM_SRC;

    logic [NUM_SRC-1:0] ev_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] mask_q;
    logic               pending;
    logic               fall;
    logic [PIPE_W-1:0]  pipe_q;

    always_comb begin
        ev_vec            = '0;
        ev_vec[SRC_TX]    = ev_tx_done;
        ev_vec[SRC_RX]    = ev_rx_ready;
        ev_vec[SRC_RETRY] = ev_max_retry;
    end

    assign clr_vec = (reg_wr && reg_addr == ADDR_STATUS) ? reg_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (reg_wr && reg_addr == ADDR_MASK) begin
            mask_q <= reg_wdata[NUM_SRC-1:0];
        end
    end

    assign pending = |(flags & ~mask_q);

    radio_irq_flags #(.N(NUM_SRC)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_vec),
        .clr   (clr_vec),
        .flags (flags)
    );

    radio_irq_fsm #(.PW(PIPE_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .pipe_in (rx_pipe),
        .irq_n   (irq_n),
        .fall    (fall),
        .pipe_q  (pipe_q)
    );

    always_comb begin
        if (reg_addr == ADDR_MASK) begin
            reg_rdata = {{(DATA_W-NUM_SRC){1'b0}}, mask_q};
        end else begin
            reg_rdata = {{PAD_HI{1'b0}}, pipe_q, {PAD_MID{1'b0}}, flags};
        end
    end

    assign rd_unreliable = reg_rd && fall;
endmodule

module radio_irq_ctrl_chk
    import radio_irq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] ev_vec,
    input logic [NUM_SRC-1:0] clr_vec,
    input logic [NUM_SRC-1:0] flags,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [PIPE_W-1:0]  pipe_q,
    input logic [PIPE_W-1:0]  rx_pipe,
    input logic               irq_n,
    input logic               reg_rd,
    input logic               rd_unreliable
);
    a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vec[0] |=> flags[0]);

    a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_vec[1] && clr_vec[1]) |=> flags[1]);

    a_r3_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[2] && !ev_vec[2]) |=> !flags[2]);

    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(irq_n) && !irq_n) |-> $past(|(flags & ~mask_q)));

    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~mask_q) == '0) |=> irq_n);

    a_r8_pipe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_n && (|(flags & ~mask_q))) |=> $stable(pipe_q));

    a_r8_pipe_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> pipe_q == $past(rx_pipe));

    a_r9_strobe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unreliable |-> (reg_rd && irq_n));
endmodule

bind radio_irq_ctrl radio_irq_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_vec        (ev_vec),
    .clr_vec       (clr_vec),
    .flags         (flags),
    .mask_q        (mask_q),
    .pipe_q        (pipe_q),
    .rx_pipe       (rx_pipe),
    .irq_n         (irq_n),
    .reg_rd        (reg_rd),
    .rd_unreliable (rd_unreliable)
);

// File: tb/radio_irq_ctrl_test.sv
module radio_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_tx_done = 1'b0, ev_rx_ready = 1'b0, ev_max_retry = 1'b0;
    logic [2:0] rx_pipe = 3'd0;
    logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rd_unreliable, irq_n;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [2:0] m_flags = 3'd0, m_mask = 3'd0, m_pipe = 3'd0;
    logic       m_irq_n = 1'b1;

    always #10 clk = ~clk;

    radio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_done(ev_tx_done), .ev_rx_ready(ev_rx_ready), .ev_max_retry(ev_max_retry),
        .rx_pipe(rx_pipe), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .rd_unreliable(rd_unreliable), .irq_n(irq_n)
    );

    function automatic logic m_pend();
        return (m_flags & ~m_mask) != 3'd0;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            logic [2:0] evs;
            logic [2:0] clr;
            logic       pend;
            evs  = {ev_max_retry, ev_rx_ready, ev_tx_done};
            clr  = (reg_wr && !reg_addr) ? reg_wdata[2:0] : 3'd0;
            pend = m_pend();
            if (m_irq_n && pend) m_pipe = rx_pipe;
            m_irq_n = !pend;
            m_flags = (m_flags & ~clr) | evs;
            if (reg_wr && reg_addr) m_mask = reg_wdata[2:0];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare every output against the model, then advance one clock
    task automatic tick();
        logic [7:0] exp_rd;
        #1;
        exp_rd = reg_addr ? {5'd0, m_mask} : {1'b0, m_pipe, 1'b0, m_flags};
        chk("R5 irq_n", irq_n, m_irq_n);
        chk("R2 rdata", reg_rdata, exp_rd);
        chk("R9 unreliable", rd_unreliable, reg_rd && m_irq_n && m_pend());
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        ev_tx_done = 0; ev_rx_ready = 0; ev_max_retry = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 irq_n", irq_n, 1);
        chk("R1 status", reg_rdata, 0);
        reg_addr = 1; #1;
        chk("R1 R10 mask", reg_rdata, 0);
        quiet();

        // transmit-done with pipe 5
        rx_pipe = 3'd5; ev_tx_done = 1; tick(); quiet();
        chk("R2 tx flag", reg_rdata, 8'h01);
        chk("R5 not yet", irq_n, 1);
        reg_rd = 1; #1;
        chk("R9 strobe", rd_unreliable, 1);
        chk("R9 stale pipe", reg_rdata[6:4], 0);
        tick(); quiet();
        chk("R5 asserted", irq_n, 0);
        chk("R8 pipe loaded", reg_rdata, 8'h51);
        rx_pipe = 3'd3; tick(); tick();
        chk("R8 pipe held", reg_rdata[6:4], 5);
        // clear
        reg_wr = 1; reg_wdata = 8'h01; tick(); quiet();
        chk("R3 cleared", reg_rdata[2:0], 0);
        chk("R7 lag", irq_n, 0);
        tick();
        chk("R7 released", irq_n, 1);

        // mask receive source
        reg_addr = 1; reg_wr = 1; reg_wdata = 8'hFA; tick(); quiet();
        reg_addr = 1; #1;
        chk("R10 mask read", reg_rdata, 8'h02);
        reg_addr = 0;
        ev_rx_ready = 1; tick(); quiet();
        repeat (4) tick();
        chk("R6 flag set", reg_rdata[1], 1);
        chk("R6 pin high", irq_n, 1);
        reg_wr = 1; reg_wdata = 8'h00; tick(); quiet();
        chk("R3 zero keeps", reg_rdata[1], 1);

        // event and clear together
        ev_max_retry = 1; tick(); quiet();
        tick();
        chk("R5 retry asserts", irq_n, 0);
        ev_max_retry = 1; reg_wr = 1; reg_wdata = 8'h04; tick(); quiet();
        chk("R4 event wins", reg_rdata[2], 1);
        reg_wr = 1; reg_wdata = 8'h04; tick(); quiet();
        reg_addr = 1; reg_wr = 1; reg_wdata = 8'h07; tick(); quiet();
        tick();
        chk("R7 masked releases", irq_n, 1);
        reg_addr = 1; reg_wr = 1; reg_wdata = 8'h00; tick(); quiet();
        reg_wr = 1; reg_wdata = 8'h07; tick(); quiet();

        // random traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            ev_tx_done   = ($urandom % 6) == 0;
            ev_rx_ready  = ($urandom % 6) == 0;
            ev_max_retry = ($urandom % 9) == 0;
            rx_pipe      = 3'($urandom);
            reg_addr     = ($urandom % 5) == 0;
            reg_wr       = ($urandom % 4) == 0;
            reg_rd       = r[0];
            reg_wdata    = 8'($urandom);
            tick();
        end
        quiet();
        tick();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule